// File: doc/BRIEF.md
# Event-Sorting Hit Distributor

This block sits between the input links of one tracker layer and a bank of pattern matchers that each work on a different bunch crossing. Every link delivers 32-bit hit words. Bits [31:24] of a hit hold an 8-bit crossing time stamp and bits [23:0] hold the hit's position within the sector. Each link writes into a private FIFO. That FIFO holds back its source through a ready signal once it is full.

The low bits of the time stamp choose an event slot. With the default four slots, the slot is bits [25:24]. Each slot owns one output lane with a valid/ready handshake. A lane collects the head entries of all link FIFOs whose next hit belongs to its slot. It then passes them out one hit per cycle, choosing among the competing links in round-robin order. Several lanes can deliver in the same cycle, so the matchers for overlapping events run side by side.

For each slot, a done flag shows whether any hit for that slot is still buffered. For each link, a sticky flag records a write that was attempted while the link's FIFO was full.

Top module: `hit_event_sorter`

## Requirements
- R1: After reset, every in_ready bit is 1, every out_valid bit is 0, every overflow bit is 0 and every slot_done bit is 1.
- R2: A hit whose bits [25:24] equal s leaves only on lane s, with all 32 bits unchanged. It appears on the lane in the cycle after the edge that accepted it, provided its FIFO was empty and the lane was idle.
- R3: Hits from one link that target the same slot leave that lane in the order they arrived.
- R4: When several links hold hits for the same slot, the lane serves them in round-robin order. After reset, link 0 has first priority. After link i is served, the search for the next grant starts at link i+1 and wraps around.
- R5: While out_valid of a lane is 1 and its out_ready is 0, the lane keeps out_valid at 1 and keeps out_data unchanged.
- R6: A link FIFO with DEPTH entries (default 4) drives its in_ready bit to 0 once it holds DEPTH hits. The bit returns to 1 after the FIFO drains.
- R7: A hit offered while its link's in_ready is 0 is dropped and never reaches any lane. It sets that link's overflow bit, which stays at 1 until reset. The overflow bits of the other links are unaffected.
- R8: slot_done[s] is 0 while any link FIFO still holds a hit for slot s. It is 1 once all such hits have left lane s.
- R9: Lanes for different slots are independent. Hits for two different slots, arriving on two different links, leave on their two lanes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | LINKS | Per-link hit offered |
| in_data | input | LINKS x HIT_W | Per-link hit word: time stamp in [31:24], position in [23:0] |
| in_ready | output | LINKS | Per-link FIFO has room |
| out_valid | output | SLOTS | Per-lane hit available |
| out_data | output | SLOTS x HIT_W | Per-lane hit word |
| out_ready | input | SLOTS | Per-lane matcher accepts the hit |
| overflow | output | LINKS | Sticky flag: a hit was offered while the FIFO was full |
| slot_done | output | SLOTS | No buffered hit remains for the slot |

## Verification
The embedded properties check, on every cycle, the following:
- each lane carries only hits of its own slot;
- a stalled lane holds its word steady;
- a lane never shows a hit while its done flag is raised;
- each arbiter grant is one-hot and covers only requesting links;
- the overflow flag sets on a write to a full FIFO and then stays set.

The directed scenarios cover what a single-cycle property cannot:
- the exact latency from input to lane;
- arrival order within one link;
- the round-robin interleaving and its wrap-around;
- two lanes delivering in the same cycle;
- the count of hits that survive a full FIFO;
- how the done flag falls and rises as a slot drains.

// File: rtl/hitdist_pkg.sv
package hitdist_pkg;
    localparam int DEF_HIT_W  = 32;
    localparam int DEF_TS_LSB = 24;
    localparam int DEF_LINKS  = 4;
    localparam int DEF_SLOTS  = 4;
    localparam int DEF_DEPTH  = 4;
endpackage

// File: rtl/hd_link_fifo.sv
module hd_link_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_valid,
    input  logic [W-1:0] wr_data,
    output logic         wr_ready,
    output logic         rd_valid,
    output logic [W-1:0] rd_data,
    input  logic         rd_pop,
    output logic         ovf
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [CW-1:0]           cnt;
        logic                    ovf;
    } fifo_st_t;

    fifo_st_t st_q, st_d;
    logic do_wr, do_rd;

    assign wr_ready = (st_q.cnt != CW'(DEPTH));
    assign rd_valid = (st_q.cnt != '0);
    assign rd_data  = st_q.mem[st_q.rp];
    assign ovf      = st_q.ovf;

    always_comb begin
        st_d  = st_q;
        do_wr = wr_valid && wr_ready;
        do_rd = rd_pop && rd_valid;
        if (do_wr) begin
            st_d.mem[st_q.wp] = wr_data;
            st_d.wp = (st_q.wp == PW'(DEPTH - 1)) ? '0 : st_q.wp + PW'(1);
        end
        if (do_rd) begin
            st_d.rp = (st_q.rp == PW'(DEPTH - 1)) ? '0 : st_q.rp + PW'(1);
        end
        st_d.cnt = st_q.cnt + CW'(do_wr) - CW'(do_rd);
        if (wr_valid && !wr_ready) begin
            st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7: a write offered to a full FIFO raises the flag on the next cycle
    assert_overflow_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> ovf);
    // R7: the flag never clears without reset
    assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);
    // R3: the lane logic pops only an entry that is present
    assert_pop_when_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pop |-> rd_valid);
    // R6: the fill level never exceeds the capacity
    assert_fill_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));
endmodule

// File: rtl/hd_rr_arb.sv
module hd_rr_arb #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         accept,
    output logic [N-1:0] grant
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [IW-1:0] last;
        logic          lock;
        logic [IW-1:0] lidx;
    } arb_st_t;

    arb_st_t st_q, st_d;
    logic [IW-1:0] sel;
    logic          found;

    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int k = 1; k <= N; k++) begin
            if (!found && req[(int'(st_q.last) + k) % N]) begin
                found = 1'b1;
                sel   = IW'((int'(st_q.last) + k) % N);
            end
        end
        if (st_q.lock) begin
            sel = st_q.lidx;
        end
        grant = '0;
        if (|req) begin
            grant[sel] = 1'b1;
        end
        st_d      = st_q;
        st_d.lock = (|req) && !accept;
        st_d.lidx = sel;
        if ((|req) && accept) begin
            st_d.last = sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{last: IW'(N - 1), lock: 1'b0, lidx: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // R4: at most one link is served per cycle
    assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R4: a grant is given only to a requesting link
    assert_grant_in_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);
    // R5: a held grant still finds its request present
    assert_lock_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |-> req[st_q.lidx]);
endmodule

// File: rtl/hit_event_sorter.sv
module hit_event_sorter
    import hitdist_pkg::*;
#(
    parameter int LINKS  = DEF_LINKS,
    parameter int SLOTS  = DEF_SLOTS,
    parameter int DEPTH  = DEF_DEPTH,
    parameter int HIT_W  = DEF_HIT_W,
    parameter int TS_LSB = DEF_TS_LSB
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [LINKS-1:0]            in_valid,
    input  logic [LINKS-1:0][HIT_W-1:0] in_data,
    output logic [LINKS-1:0]            in_ready,
    output logic [SLOTS-1:0]            out_valid,
    output logic [SLOTS-1:0][HIT_W-1:0] out_data,
    input  logic [SLOTS-1:0]            out_ready,
    output logic [LINKS-1:0]            overflow,
    output logic [SLOTS-1:0]            slot_done
);
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int CNT_W  = $clog2(LINKS * DEPTH + 1);

    typedef struct packed {
        logic [SLOTS-1:0][CNT_W-1:0] cnt;
    } occ_st_t;

    occ_st_t st_q, st_d;

    logic [LINKS-1:0]                head_valid;
    logic [LINKS-1:0][HIT_W-1:0]     head_data;
    logic [LINKS-1:0]                pop;
    logic [SLOTS-1:0][LINKS-1:0]     req;
    logic [SLOTS-1:0][LINKS-1:0]     grant;

    for (genvar l = 0; l < LINKS; l++) begin : g_link
        hd_link_fifo #(.W(HIT_W), .DEPTH(DEPTH)) u_fifo (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_valid (in_valid[l]),
            .wr_data  (in_data[l]),
            .wr_ready (in_ready[l]),
            .rd_valid (head_valid[l]),
            .rd_data  (head_data[l]),
            .rd_pop   (pop[l]),
            .ovf      (overflow[l])
        );
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        for (genvar l = 0; l < LINKS; l++) begin : g_req
            assign req[s][l] = head_valid[l] &&
                (head_data[l][TS_LSB +: SLOT_W] == SLOT_W'(s));
        end

        hd_rr_arb #(.N(LINKS)) u_arb (
            .clk    (clk),
            .rst_n  (rst_n),
            .req    (req[s]),
            .accept (out_ready[s]),
            .grant  (grant[s])
        );

        assign slot_done[s] = (st_q.cnt[s] == '0);

        // R2: a lane only ever carries hits of its own slot
        assert_lane_slot_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[s] |-> (out_data[s][TS_LSB +: SLOT_W] == SLOT_W'(s)));
        // R5: a stalled lane holds its word
        assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[s] && !out_ready[s]) |=> (out_valid[s] && $stable(out_data[s])));
        // R8: a lane with a pending hit cannot report its slot as drained
        assert_done_vs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[s] |-> !slot_done[s]);
    end

    always_comb begin
        pop = '0;
        for (int s = 0; s < SLOTS; s++) begin
            out_valid[s] = |req[s];
            out_data[s]  = '0;
            for (int l = 0; l < LINKS; l++) begin
                if (grant[s][l]) begin
                    out_data[s] = head_data[l];
                    if (out_ready[s]) begin
                        pop[l] = 1'b1;
                    end
                end
            end
        end
    end

    always_comb begin
        st_d = st_q;
        for (int s = 0; s < SLOTS; s++) begin
            logic [CNT_W-1:0] inc;
            inc = '0;
            for (int l = 0; l < LINKS; l++) begin
                if (in_valid[l] && in_ready[l] &&
                    in_data[l][TS_LSB +: SLOT_W] == SLOT_W'(s)) begin
                    inc = inc + CNT_W'(1);
                end
            end
            st_d.cnt[s] = st_q.cnt[s] + inc - CNT_W'(out_valid[s] && out_ready[s]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: tb/hit_event_sorter_tb.sv
module hit_event_sorter_tb;
    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [3:0]             in_valid = '0;
    logic [3:0][31:0]       in_data = '0;
    logic [3:0]             in_ready;
    logic [3:0]             out_valid;
    logic [3:0][31:0]       out_data;
    logic [3:0]             out_ready = '0;
    logic [3:0]             overflow;
    logic [3:0]             slot_done;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    hit_event_sorter u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_ready (out_ready),
        .overflow  (overflow),
        .slot_done (slot_done)
    );

    function automatic logic [31:0] mk(input logic [7:0] ts, input logic [23:0] pos);
        return {ts, pos};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // all tasks start and end right after a falling edge
    task automatic push_many(input logic [3:0] mask, input logic [3:0][31:0] words);
        in_valid = mask;
        in_data  = words;
        @(negedge clk);
        in_valid = '0;
    endtask

    task automatic push_one(input int link, input logic [31:0] w);
        logic [3:0][31:0] words;
        logic [3:0]       mask;
        words = '0;
        mask  = '0;
        words[link] = w;
        mask[link]  = 1'b1;
        push_many(mask, words);
    endtask

    task automatic drain(input int slot, input int n, input logic [3:0][31:0] exp, input string req);
        out_ready[slot] = 1'b1;
        for (int k = 0; k < n; k++) begin
            chk(out_valid[slot] && out_data[slot] == exp[k], req, out_data[slot], exp[k]);
            @(negedge clk);
        end
        out_ready[slot] = 1'b0;
    endtask

    task automatic t_reset;
        chk(in_ready == 4'hF, "R1 in_ready", 32'(in_ready), 32'hF);
        chk(out_valid == 4'h0, "R1 out_valid", 32'(out_valid), 32'h0);
        chk(overflow == 4'h0, "R1 overflow", 32'(overflow), 32'h0);
        chk(slot_done == 4'hF, "R1 slot_done", 32'(slot_done), 32'hF);
    endtask

    task automatic t_route;
        logic [31:0] h;
        h = mk(8'h06, 24'h123456);
        push_one(1, h);
        chk(out_valid == 4'b0100, "R2 lane select", 32'(out_valid), 32'h4);
        chk(out_data[2] == h, "R2 data", out_data[2], h);
        chk(slot_done == 4'b1011, "R8 done low while held", 32'(slot_done), 32'hB);
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            chk(out_valid[2] && out_data[2] == h, "R5 stall hold", out_data[2], h);
        end
        drain(2, 1, {96'h0, h}, "R2 drain");
        chk(out_valid == 4'h0, "R2 empty after pop", 32'(out_valid), 32'h0);
        chk(slot_done == 4'hF, "R8 done high after drain", 32'(slot_done), 32'hF);
    endtask

    task automatic t_order;
        logic [3:0][31:0] e;
        e = '0;
        e[0] = mk(8'h01, 24'h00000A);
        e[1] = mk(8'h05, 24'h00000B);
        e[2] = mk(8'h09, 24'h00000C);
        for (int k = 0; k < 3; k++) push_one(0, e[k]);
        drain(1, 3, e, "R3 link order");
    endtask

    task automatic t_rr;
        logic [3:0][31:0] w;
        logic [3:0][31:0] e;
        w = '0;
        w[0] = mk(8'h03, 24'h000100);
        w[2] = mk(8'h07, 24'h000200);
        push_many(4'b0101, w);
        e[0] = w[0];
        e[1] = w[2];
        w[0] = mk(8'h0B, 24'h000101);
        w[2] = mk(8'h0F, 24'h000201);
        push_many(4'b0101, w);
        e[2] = w[0];
        e[3] = w[2];
        drain(3, 4, e, "R4 interleave");
        // last grant went to link 2, so the search restarts at link 3
        for (int l = 0; l < 4; l++) w[l] = mk(8'(8'h13 + 4 * l), 24'(24'h000300 + l));
        push_many(4'b1111, w);
        e[0] = w[3];
        e[1] = w[0];
        e[2] = w[1];
        e[3] = w[2];
        drain(3, 4, e, "R4 wrap");
    endtask

    task automatic t_par;
        logic [3:0][31:0] w;
        w = '0;
        w[0] = mk(8'h20, 24'h000AAA);
        w[1] = mk(8'h21, 24'h000BBB);
        out_ready = 4'b0011;
        push_many(4'b0011, w);
        chk(out_valid == 4'b0011, "R9 both lanes", 32'(out_valid), 32'h3);
        chk(out_data[0] == w[0], "R9 lane0 data", out_data[0], w[0]);
        chk(out_data[1] == w[1], "R9 lane1 data", out_data[1], w[1]);
        @(negedge clk);
        chk(out_valid == 4'h0, "R9 both popped", 32'(out_valid), 32'h0);
        out_ready = '0;
    endtask

    task automatic t_full;
        logic [3:0][31:0] e;
        for (int k = 0; k < 4; k++) begin
            e[k] = mk(8'(4 * k), 24'(24'h00F000 + k));
            push_one(2, e[k]);
        end
        chk(in_ready == 4'b1011, "R6 full stalls", 32'(in_ready), 32'hB);
        push_one(2, mk(8'h10, 24'hDEAD00));
        chk(overflow == 4'b0100, "R7 overflow set", 32'(overflow), 32'h4);
        drain(0, 4, e, "R7 stored hits");
        chk(out_valid[0] == 1'b0, "R7 dropped hit absent", 32'(out_valid), 32'h0);
        chk(overflow == 4'b0100, "R7 sticky", 32'(overflow), 32'h4);
        chk(in_ready == 4'hF, "R6 ready after drain", 32'(in_ready), 32'hF);
        chk(slot_done == 4'hF, "R8 done after full drain", 32'(slot_done), 32'hF);
    endtask

    task automatic t_done;
        logic [31:0] x;
        logic [31:0] y;
        x = mk(8'h02, 24'h00C001);
        y = mk(8'h0A, 24'h00C002);
        push_one(3, x);
        push_one(0, y);
        chk(slot_done == 4'b1011, "R8 two held", 32'(slot_done), 32'hB);
        drain(2, 1, {96'h0, x}, "R8 first out");
        chk(slot_done == 4'b1011, "R8 one left", 32'(slot_done), 32'hB);
        drain(2, 1, {96'h0, y}, "R8 second out");
        chk(slot_done == 4'hF, "R8 slot drained", 32'(slot_done), 32'hF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_route();
        t_order();
        t_rr();
        t_par();
        t_full();
        t_done();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule